// File: doc/BRIEF.md
# Word Shifter with Carry Flag

This block shifts a 32-bit word left or right, either logically with zero fill or arithmetically with sign fill. Each operation is issued in one cycle and its result is registered, so the result appears one cycle later. The shift amount comes from one of two places. One is the low bits of a register operand, where one extra bit above the 5-bit range forces a saturated shift. The other is a 5-bit immediate field.

For arithmetic right shifts the block also produces a carry. The carry reports whether a negative word lost any 1-bits during the shift. A qualifier output tells the surrounding flag logic when the carry is meaningful. For logical shifts the qualifier stays low, and the stored flag keeps its old value.

Top module: `word_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `carry` and `carry_valid` are all zero after that edge.
- R2: Every output is registered. The outputs after an edge reflect the inputs sampled at that edge, so each operation has exactly one cycle of latency.
- R3: `op_sel` = 2'b00 shifts left logically. Vacated low bits are filled with zeros.
- R4: `op_sel` = 2'b01 shifts right logically. Vacated high bits are filled with zeros.
- R5: When the amount comes from the register (`use_imm` = 0) and `reg_amt[5]` is 1, a logical shift gives zero. When `reg_amt[5]` is 0, the word is shifted by `reg_amt[4:0]`.
- R6: `op_sel[1]` = 1 selects an arithmetic right shift. For amounts 1 to 31 the result is filled with copies of the sign bit. `carry` is 1 exactly when the source is negative and at least one 1-bit was shifted out.
- R7: For a register-amount arithmetic shift with `reg_amt[5]` = 1, the result is all ones if the source is negative and zero otherwise. `carry` equals the source sign bit.
- R8: An arithmetic shift by zero returns the source unchanged and clears `carry`. This holds for both amount sources.
- R9: A source with bit 31 clear always gives `carry` = 0.
- R10: `carry_valid` is 1 after arithmetic shifts and 0 after logical shifts. `carry` is 0 whenever `carry_valid` is 0.
- R11: Only `reg_amt[5:0]` is examined. Bits 31 to 6 of `reg_amt` have no effect on any output.
- R12: When `use_imm` = 1, the amount is `imm_amt` (0 to 31) and `reg_amt` has no effect. No saturation applies in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | 32 | Word to shift |
| reg_amt | input | 32 | Register operand; bits 5:0 give the amount |
| imm_amt | input | 5 | Immediate shift amount |
| use_imm | input | 1 | 1 selects `imm_amt`, 0 selects `reg_amt` |
| op_sel | input | 2 | 00 left logical, 01 right logical, 1x right arithmetic |
| result | output | 32 | Registered shifted word |
| carry | output | 1 | Registered carry for arithmetic shifts |
| carry_valid | output | 1 | Registered qualifier: carry is meaningful |

## Verification
On every cycle the assertions check the following, each against the inputs of the previous cycle:
- the carry qualifier and zero carry after logical shifts;
- the saturated results for both logical and arithmetic register shifts;
- carry never set for a non-negative source;
- the pass-through of a zero-amount arithmetic shift.

Only the bench's sweeps can show that every amount from 0 to 63 gives the exact shifted word and the exact lost-bit carry. Across several source patterns, the sweeps also show that the upper register bits and the unused amount source are truly ignored.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LEFT      = 2'b00,
    SHF_RIGHT     = 2'b01,
    SHF_ARITH     = 2'b10,
    SHF_ARITH_ALT = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  reg_amt,
  input  logic [AW-1:0] imm_amt,
  input  logic          use_imm,
  output logic [AW-1:0] amt,
  output logic          sat
);
  // The register amount carries one bit above the in-range field; it saturates.
  always_comb begin
    if (use_imm) begin
      amt = imm_amt;
      sat = 1'b0;
    end else begin
      amt = reg_amt[AW-1:0];
      sat = reg_amt[AW];
    end
  end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  output logic [W-1:0]  res,
  output logic          lost
);
  logic [W-1:0]        flipped;
  logic [W-1:0]        stage_in;
  logic [W-1:0]        unflip;
  logic [AW:0][W-1:0]  stg;
  logic [AW:0]         gone;
  logic                fill;

  // Left shifts reuse the right-shift network on a bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign flipped[i] = data[W-1-i];
    assign unflip[i]  = stg[AW][W-1-i];
  end

  assign stage_in = to_left ? flipped : data;
  assign fill     = arith & data[W-1];
  assign stg[0]   = stage_in;
  assign gone[0]  = 1'b0;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1]  = amt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    assign gone[k+1] = gone[k] | (amt[k] & (|stg[k][S-1:0]));
  end

  assign res  = to_left ? unflip : stg[AW];
  assign lost = gone[AW];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_word,
  input  logic [W-1:0]  reg_amt,
  input  logic [AW-1:0] imm_amt,
  input  logic          use_imm,
  input  logic [1:0]    op_sel,
  output logic [W-1:0]  result,
  output logic          carry,
  output logic          carry_valid
);
  import shf_pkg::*;

  logic [AW-1:0] amt;
  logic          sat;
  logic          to_left;
  logic          arith;
  logic          sign;
  logic [W-1:0]  core_res;
  logic          core_lost;
  logic [W-1:0]  res_n;
  logic          carry_n;

  assign to_left = (shf_op_e'(op_sel) == SHF_LEFT);
  assign arith   = op_sel[1];
  assign sign    = src_word[W-1];

  shf_amount_sel #(.W(W), .AW(AW)) u_amt (
    .reg_amt (reg_amt),
    .imm_amt (imm_amt),
    .use_imm (use_imm),
    .amt     (amt),
    .sat     (sat)
  );

  shf_core #(.W(W), .AW(AW)) u_core (
    .data    (src_word),
    .amt     (amt),
    .to_left (to_left),
    .arith   (arith),
    .res     (core_res),
    .lost    (core_lost)
  );

  always_comb begin
    if (sat) res_n = arith ? {W{sign}} : '0;
    else     res_n = core_res;
    // A saturated shift moves every bit out, including the sign bit.
    carry_n = arith & sign & (sat | core_lost);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      carry       <= 1'b0;
      carry_valid <= 1'b0;
    end else begin
      result      <= res_n;
      carry       <= carry_n;
      carry_valid <= arith;
    end
  end
endmodule

// File: rtl/word_shifter_chk.sv
module word_shifter_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  src_word,
  input logic [W-1:0]  reg_amt,
  input logic [AW-1:0] imm_amt,
  input logic          use_imm,
  input logic [1:0]    op_sel,
  input logic [W-1:0]  result,
  input logic          carry,
  input logic          carry_valid
);
  p_logic_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_sel[1]) |=> (!carry_valid && !carry));

  p_arith_flag_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel[1]) |=> carry_valid);

  p_pos_no_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (!src_word[W-1]) |=> !carry);

  p_logic_sat_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!use_imm && reg_amt[AW] && !op_sel[1]) |=> (result == '0));

  p_arith_sat_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (!use_imm && reg_amt[AW] && op_sel[1]) |=>
      (result == {W{$past(src_word[W-1])}} && carry == $past(src_word[W-1])));

  p_arith_zero_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel[1] && (use_imm ? (imm_amt == '0) : (reg_amt[AW:0] == '0))) |=>
      (result == $past(src_word) && !carry));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry && !carry_valid));
endmodule

bind word_shifter word_shifter_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/word_shifter_tb.sv
module word_shifter_tb;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  src_word;
  logic [W-1:0]  reg_amt;
  logic [AW-1:0] imm_amt;
  logic          use_imm;
  logic [1:0]    op_sel;
  logic [W-1:0]  result;
  logic          carry;
  logic          carry_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  word_shifter #(.W(W), .AW(AW)) u_dut (
    .clk, .rst, .src_word, .reg_amt, .imm_amt, .use_imm, .op_sel,
    .result, .carry, .carry_valid
  );

  task automatic check(input string req, input logic [W-1:0] r, input logic c,
                       input logic v, input logic [W-1:0] er, input logic ec,
                       input logic ev);
    checks++;
    if (r !== er || c !== ec || v !== ev) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b v=%b expected res=%h c=%b v=%b (src=%h ramt=%h imm=%0d ui=%b op=%b)",
               req, r, c, v, er, ec, ev, src_word, reg_amt, imm_amt, use_imm, op_sel);
    end
  endtask

  // Drive at negedge, result is registered at the next posedge, sample at the following negedge.
  task automatic run(input logic [W-1:0] s, input logic [W-1:0] ra, input logic [AW-1:0] ia,
                     input logic ui, input logic [1:0] op);
    logic [63:0] wide;
    logic [W-1:0] er;
    logic ec;
    logic ev;
    int n;
    bit sat;
    string req;
    src_word = s; reg_amt = ra; imm_amt = ia; use_imm = ui; op_sel = op;
    n   = ui ? int'(ia) : int'(ra[4:0]);
    sat = !ui && ra[5];
    ev  = op[1];
    ec  = 1'b0;
    if (op == 2'b00) begin
      req = sat ? "R5" : (ui ? "R12/R3" : "R3/R11");
      wide = {32'h0, s} << n;
      er = sat ? '0 : wide[31:0];
    end else if (op == 2'b01) begin
      req = sat ? "R5" : (ui ? "R12/R4" : "R4/R11");
      er = sat ? '0 : (s >> n);
    end else begin
      if (sat) begin
        req = "R7";
        er  = {W{s[31]}};
        ec  = s[31];
      end else begin
        req = (n == 0) ? "R8" : (s[31] ? "R6" : "R9");
        er  = W'($signed(s) >>> n);
        wide = (64'd1 << n) - 64'd1;
        ec  = s[31] && ((s & wide[31:0]) != '0);
      end
    end
    @(negedge clk);
    check(req, result, carry, carry_valid, er, ec, ev);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h7FFF_FFFF; pats[4] = 32'hDEAD_BEEF; pats[5] = 32'h1234_5678;
    pats[6] = 32'h8000_0001; pats[7] = 32'hF000_0000;

    rst = 1'b1; src_word = '1; reg_amt = '0; imm_amt = '0; use_imm = 1'b0; op_sel = 2'b10;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", result, carry, carry_valid, '0, 1'b0, 1'b0);
    rst = 1'b0;

    // R2: latency - result changes one edge after input, not before
    src_word = 32'h0000_0001; reg_amt = 32'd4; use_imm = 1'b0; op_sel = 2'b00;
    #1;
    check("R2", result, carry, carry_valid, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2", result, carry, carry_valid, 32'h10, 1'b0, 1'b0);

    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 64; a++) begin
        for (int op = 0; op < 4; op++) begin
          // R11: vary bits 31:6 of the register amount
          logic [W-1:0] hi;
          hi = (32'(p * 64 + a) * 32'h9E37_79B9) & 32'hFFFF_FFC0;
          run(pats[p], hi | 32'(a), AW'(a * 7), 1'b0, 2'(op));
        end
      end
      for (int a = 0; a < 32; a++) begin
        for (int op = 0; op < 4; op++) begin
          // R12: register amount is junk, including bit 5
          run(pats[p], 32'hFFFF_FFE0 ^ 32'(a * 3), AW'(a), 1'b1, 2'(op));
        end
      end
    end

    // R1: reset after activity clears outputs
    src_word = 32'h8000_0001; reg_amt = 32'd1; use_imm = 1'b0; op_sel = 2'b10;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, carry, carry_valid, '0, 1'b0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule